// File: doc/BRIEF.md
# Sequential Matrix-Vector Multiplier

This block multiplies a 5x5 matrix of unsigned words by a 5-element unsigned vector and returns a 5-element result vector. The caller places all 25 matrix words and all 5 vector words on two flat input buses. The matrix goes in row-major order. Both buses must stay stable for the whole run.

A single-cycle `start` pulse while the block is idle begins a computation. One multiply-accumulate unit then walks every row, one column per clock. When a row is finished, its result is written to that row's result register, and the row's own valid strobe pulses. After the last row, `done` and `ready` pulse together, and the block goes back to idle.

All arithmetic uses 15-bit unsigned words and wraps modulo 2^15. This covers the operands, each product and the running sum. A full run takes 25 busy cycles, one finish cycle, and then idle.

Top module: `mv_mac_engine`

## Requirements
- R1: While reset (synchronous, active high) is asserted, and in the cycle after it, `idle` is 1 and `done`, `ready` and every bit of `res_vld` are 0.
- R2: Matrix element (i, j) is taken from `mat_flat[(i*5+j)*15 +: 15]`. Vector element j is taken from `vec_flat[j*15 +: 15]`. Result i appears on `res_flat[i*15 +: 15]` and equals the sum over j of matrix(i, j)*vector(j).
- R3: Products and the running sum are truncated modulo 2^15. For example, a row of five 32767 terms times a vector of 32767 gives 5.
- R4: The running sum is cleared at the start of every row and every run. No earlier row or earlier run leaks into a result.
- R5: `res_vld[i]` is high for exactly one cycle, in the cycle when result i first shows its new value. The strobes come in the order 0 to 4. When start is sampled at clock edge 0, `res_vld[i]` is high in cycle 5*(i+1)+1.
- R6: `done` and `ready` are always equal. They pulse for one cycle, in cycle 26 after start is sampled, which is the same cycle as `res_vld[4]`.
- R7: `idle` is low from the cycle after start is sampled through the `done` cycle, and high otherwise. A `start` pulse while not idle is ignored.
- R8: While idle, the result outputs keep their values until the next accepted start.
- R9: A reset asserted in the middle of a run abandons the run. No `done` or strobe follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle start request, sampled only while idle |
| mat_flat | input | 375 | 25 matrix words, row-major, element k at bits k*15 +: 15 |
| vec_flat | input | 75 | 5 vector words, element j at bits j*15 +: 15 |
| res_flat | output | 75 | 5 result words, element i at bits i*15 +: 15 |
| res_vld | output | 5 | Per-result one-cycle valid strobe |
| done | output | 1 | One-cycle completion pulse |
| idle | output | 1 | High when no computation runs |
| ready | output | 1 | One-cycle pulse, equal to done |

## Verification
A wrong row or column counter shows up as a strobe that moves away from cycles 6, 11, 16, 21 or 26, and as a result in the wrong word. Either appears within the first 26 cycles of a run. An accumulator that is not cleared corrupts the next row's result right away, five cycles later. A test vector with zeros on every other row exposes this directly. A wrong state register shows up as `idle` or `done` at the wrong cycle, or as a second run started by a pulse that should have been ignored. Both are visible within one run.

// File: rtl/mv_mac_engine.sv
module mv_mac_engine #(
  parameter int N = 5,
  parameter int W = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [N*N*W-1:0] mat_flat,
  input  logic [N*W-1:0]   vec_flat,
  output logic [N*W-1:0]   res_flat,
  output logic [N-1:0]     res_vld,
  output logic             done,
  output logic             idle,
  output logic             ready
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;
  localparam logic [IW-1:0] LAST = IW'(N - 1);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} st_t;

  st_t            st;
  logic [IW-1:0]  row, col;
  logic [W-1:0]   acc, a_sel, b_sel, prod, acc_nxt;
  logic [W-1:0]   res_q [N];

  assign a_sel   = mat_flat[(int'(row) * N + int'(col)) * W +: W];
  assign b_sel   = vec_flat[int'(col) * W +: W];
  assign prod    = a_sel * b_sel;
  assign acc_nxt = acc + prod;

  assign idle  = (st == S_IDLE);
  assign done  = (st == S_FIN);
  assign ready = done;

  for (genvar i = 0; i < N; i++) begin : g_out
    assign res_flat[i*W +: W] = res_q[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_IDLE;
      row     <= '0;
      col     <= '0;
      acc     <= '0;
      res_vld <= '0;
    end else begin
      res_vld <= '0;
      case (st)
        S_IDLE:
          if (start) begin
            st  <= S_RUN;
            row <= '0;
            col <= '0;
            acc <= '0;
          end
        S_RUN:
          if (col == LAST) begin
            res_vld[row] <= 1'b1;
            acc <= '0;
            col <= '0;
            if (row == LAST) st <= S_FIN;
            else             row <= row + 1'b1;
          end else begin
            acc <= acc_nxt;
            col <= col + 1'b1;
          end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst && st == S_RUN && col == LAST)
      res_q[row] <= acc_nxt;
  end
endmodule

module mv_mac_engine_chk #(
  parameter int N = 5,
  parameter int W = 15
) (
  input logic           clk,
  input logic           rst,
  input logic           start,
  input logic [N*W-1:0] res_flat,
  input logic [N-1:0]   res_vld,
  input logic           done,
  input logic           idle,
  input logic           ready
);
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (idle && !done && res_vld == '0));

  a_r5_one_strobe: assert property (@(posedge clk) disable iff (rst)
    $onehot0(res_vld));

  a_r5_strobe_pulse: assert property (@(posedge clk) disable iff (rst)
    (|res_vld) |=> !(|res_vld));

  a_r6_done_is_ready: assert property (@(posedge clk) disable iff (rst)
    done == ready);

  a_r6_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> (!done && idle));

  a_r6_done_with_last: assert property (@(posedge clk) disable iff (rst)
    done |-> res_vld[N-1]);

  a_r7_start_leaves_idle: assert property (@(posedge clk) disable iff (rst)
    (idle && start) |=> !idle);

  a_r7_busy_not_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !idle);

  a_r8_hold_idle: assert property (@(posedge clk) disable iff (rst)
    (idle && !start) |=> $stable(res_flat));
endmodule

bind mv_mac_engine mv_mac_engine_chk #(.N(N), .W(W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .res_flat(res_flat),
  .res_vld(res_vld), .done(done), .idle(idle), .ready(ready)
);

// File: tb/mv_mac_engine_tb.sv
`timescale 1ns/1ps
module mv_mac_engine_tb;
  localparam int N = 5;
  localparam int W = 15;
  localparam int NC = 5;

  localparam int MAT [NC][25] = '{
    '{82,10,16,15,66, 91,28,98,43,4, 13,55,96,92,85, 92,96,49,80,94, 64,97,81,96,68},
    '{32767,32767,32767,32767,32767, 32767,32767,32767,32767,32767,
      32767,32767,32767,32767,32767, 32767,32767,32767,32767,32767,
      32767,32767,32767,32767,32767},
    '{1,0,0,0,0, 0,1,0,0,0, 0,0,1,0,0, 0,0,0,1,0, 0,0,0,0,1},
    '{20000,20000,20000,20000,20000, 0,0,0,0,0, 20000,20000,20000,20000,20000, 0,0,0,0,0, 0,0,0,0,0},
    '{0,0,0,0,1, 0,0,0,0,0, 0,0,0,0,0, 0,0,0,0,0, 0,0,0,0,0}
  };
  localparam int VEC [NC][5] = '{
    '{76,75,40,66,18}, '{32767,32767,32767,32767,32767}, '{1,2,3,4,5},
    '{1,1,1,1,1}, '{0,0,0,0,9}
  };
  localparam int EXP [NC][5] = '{
    '{9800,15846,16555,23124,22939}, '{5,5,5,5,5}, '{1,2,3,4,5},
    '{1696,0,1696,0,0}, '{9,0,0,0,0}
  };
  localparam string TAG [NC] = '{"R2", "R3", "R2", "R4", "R2"};

  logic clk = 0, rst = 1, start = 0;
  logic [N*N*W-1:0] mat_flat = '0;
  logic [N*W-1:0] vec_flat = '0, res_flat;
  logic [N-1:0] res_vld;
  logic done, idle, ready;
  int tests = 0, fails = 0;

  always #2.5 clk = ~clk;

  mv_mac_engine #(.N(N), .W(W)) u_dut (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic load(input int k);
    for (int e = 0; e < 25; e++) mat_flat[e*W +: W] = W'(MAT[k][e]);
    for (int j = 0; j < 5; j++) vec_flat[j*W +: W] = W'(VEC[k][j]);
  endtask

  task automatic run(input int k, input int extra_start_at);
    int vbad, dbad, ibad;
    vbad = 0; dbad = 0; ibad = 0;
    @(negedge clk); load(k); start = 1;
    @(posedge clk); #1 start = 0;
    for (int c = 1; c <= 30; c++) begin
      @(negedge clk);
      for (int i = 0; i < N; i++)
        if (res_vld[i] != (c == 5*(i+1)+1)) vbad++;
      if (done != (c == 26) || ready != done) dbad++;
      if (idle != (c >= 27)) ibad++;
      if (c == extra_start_at) start = 1;
      else start = 0;
    end
    chk(vbad == 0, "R5 strobe timing", vbad, 0);
    chk(dbad == 0, "R6 done/ready timing", dbad, 0);
    chk(ibad == 0, "R7 idle timing", ibad, 0);
    for (int i = 0; i < N; i++)
      chk(res_flat[i*W +: W] == W'(EXP[k][i]), TAG[k], int'(res_flat[i*W +: W]), EXP[k][i]);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(idle == 1 && done == 0 && ready == 0 && res_vld == '0, "R1 reset state", int'(idle), 1);
    rst = 0;
    for (int k = 0; k < NC; k++) run(k, 0);

    repeat (10) @(negedge clk);
    chk(res_flat[0 +: W] == 15'd9 && idle, "R8 hold while idle", int'(res_flat[0 +: W]), 9);

    run(0, 10);
    chk(idle == 1, "R7 busy start ignored", int'(idle), 1);

    @(negedge clk); load(2); start = 1;
    @(posedge clk); #1 start = 0;
    repeat (8) @(negedge clk);
    rst = 1;
    @(negedge clk);
    chk(idle == 1 && res_vld == '0 && done == 0, "R1 mid-run reset", int'(idle), 1);
    rst = 0;
    begin
      int seen;
      seen = 0;
      repeat (30) begin
        @(negedge clk);
        if (done || res_vld != '0) seen++;
      end
      chk(seen == 0, "R9 abandoned run silent", seen, 0);
    end

    run(3, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule